// File: doc/BRIEF.md
# General-Purpose I/O Port with Set/Clear and Direction Registers

This block is a general-purpose I/O port that software controls through a simple single-cycle register bus. The number of pins is a parameter and equals the register width, which is 8, 16, 32 or 64. Each pin has three signals: a driven value, an output enable, and an input. The input passes through a two-stage synchroniser before any register can read it.

Software can change the driven values in two ways. It can write the whole word at once, or it can use a write-one-to-set register and a write-one-to-clear register, which change only the selected lines with no read-modify-write. The direction is held in one state vector. Two registers give access to it with opposite polarity: in one a 1 means output, in the other a 1 means input. Because both are views of the same vector, the two never disagree.

Reading the pin-state register returns the synchronised input for input lines and the driven value for output lines. A parameter reverses the bit numbering, so that line n sits at register bit WIDTH-1-n. Read data is registered and appears one cycle after the read is accepted.

Top module: `gpio_mmio_port`

## Requirements
- R1: After reset every line is an input (pin_oe_o all 0), every driven value is 0 (pin_o all 0), the output-direction register reads 0 and the input-direction register reads all ones.
- R2: A read of the pin-state register (word address 0) returns, for each output line, its driven value and, for each input line, the value of pin_i. A pin_i change that is stable for three clock edges before the read edge is visible in the read.
- R3: A write to the pin-state register (address 0) loads every driven value from the write data.
- R4: A write to the set register (address 1) makes each line whose bit is 1 drive high. Lines whose bits are 0 keep their value.
- R5: A write to the clear register (address 2) makes each line whose bit is 1 drive low. Lines whose bits are 0 keep their value.
- R6: The output-direction register (address 3) is read/write. A 1 makes the line an output, and pin_oe_o follows it from the cycle after the write.
- R7: The input-direction register (address 4) is read/write. A 1 makes the line an input, and a read always returns the bitwise complement of the output-direction register.
- R8: Reads of the set and clear registers return the driven value of every line, whatever the line's direction.
- R9: With BIG_END=1, line n maps to register bit WIDTH-1-n in every register, for both reads and writes.
- R10: rdata_o is updated only on the clock edge that accepts a read, one cycle after the request. It holds its value through writes and idle cycles.
- R11: Writes to addresses 5 to 7 are ignored, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Word address |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | WIDTH | Registered read data |
| pin_i | input | WIDTH | Pin inputs (asynchronous) |
| pin_o | output | WIDTH | Driven pin values |
| pin_oe_o | output | WIDTH | Pin output enables |

## Verification
A corrupted output or direction bit shows up on pin_o or pin_oe_o at the very next clock edge. A set or clear that disturbs unselected lines therefore appears at once, before any readback. A mistake in the readback selection, such as returning the pad value for an output line, appears only when the pin-state register is read while pin_i differs from the driven value. The bench keeps the two apart for that reason. A wrong bit order shows up as a mirrored pattern on the big-endian instance, which shares the bus with the normal instance.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    REG_PINS    = 3'd0,
    REG_SET     = 3'd1,
    REG_CLR     = 3'd2,
    REG_DIR_OUT = 3'd3,
    REG_DIR_IN  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_bit_order.sv
module gpio_bit_order #(
  parameter int WIDTH   = 32,
  parameter bit REVERSE = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] y_o
);
  generate
    if (REVERSE) begin : g_rev
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign y_o[i] = a_i[WIDTH-1-i];
      end
    end else begin : g_fwd
      assign y_o = a_i;
    end
  endgenerate
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wline,
  output logic [WIDTH-1:0]  out_q,
  output logic [WIDTH-1:0]  dir_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '0;
    end else if (wr_en) begin
      case (addr)
        REG_PINS:    out_q <= wline;
        REG_SET:     out_q <= out_q | wline;
        REG_CLR:     out_q <= out_q & ~wline;
        REG_DIR_OUT: dir_q <= wline;
        REG_DIR_IN:  dir_q <= ~wline;
        default:     ;
      endcase
    end
  end

  // R4
  set_hits_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_SET) |=> ((out_q & $past(wline)) == $past(wline)));

  // R4
  set_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_SET) |=> ((out_q & ~$past(wline)) == ($past(out_q) & ~$past(wline))));

  // R5
  clr_hits_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_CLR) |=> ((out_q & $past(wline)) == '0));

  // R11
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr > REG_DIR_IN) |=> ($stable(out_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_read_port.sv
module gpio_read_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  out_q,
  input  logic [WIDTH-1:0]  dir_q,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  rline_q
);
  logic [WIDTH-1:0] rd_next;

  always_comb begin
    case (addr)
      REG_PINS:         rd_next = (dir_q & out_q) | (~dir_q & pin_sync);
      REG_SET, REG_CLR: rd_next = out_q;
      REG_DIR_OUT:      rd_next = dir_q;
      REG_DIR_IN:       rd_next = ~dir_q;
      default:          rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rline_q <= '0;
    else if (rd_en) rline_q <= rd_next;
  end

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rline_q));

  // R8
  set_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == REG_SET) |=> (rline_q == $past(out_q)));
endmodule

// File: rtl/gpio_mmio_port.sv
module gpio_mmio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter bit BIG_END = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pin_o,
  output logic [WIDTH-1:0]  pin_oe_o
);
  logic [WIDTH-1:0] wline, rline, pin_sync, out_q, dir_q;
  logic             wr_en, rd_en;

  assign wr_en = sel_i & we_i;
  assign rd_en = sel_i & ~we_i;

  gpio_bit_order #(.WIDTH(WIDTH), .REVERSE(BIG_END)) u_wmap (
    .a_i(wdata_i), .y_o(wline));

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d_i(pin_i), .q_o(pin_sync));

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr_i), .wline(wline),
    .out_q(out_q), .dir_q(dir_q));

  gpio_read_port #(.WIDTH(WIDTH)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr_i), .out_q(out_q),
    .dir_q(dir_q), .pin_sync(pin_sync), .rline_q(rline));

  gpio_bit_order #(.WIDTH(WIDTH), .REVERSE(BIG_END)) u_rmap (
    .a_i(rline), .y_o(rdata_o));

  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_o == '0 && pin_oe_o == '0));

  // R6
  dir_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr_i == REG_DIR_OUT) |=> (pin_oe_o == $past(wline)));
endmodule

// File: tb/gpio_mmio_port_tb.sv
`timescale 1ns/1ps
module gpio_mmio_port_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sel = 1'b0, we = 1'b0;
  logic [2:0]   addr = '0;
  logic [W-1:0] wdata = '0, pins = '0;
  logic [W-1:0] rd_le, rd_be, po_le, po_be, oe_le, oe_be;

  logic [W-1:0] m_out_le = '0, m_dir_le = '0, m_out_be = '0, m_dir_be = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_mmio_port #(.WIDTH(W), .BIG_END(1'b0)) dut_i (
    .clk(clk), .rst(rst), .sel_i(sel), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd_le), .pin_i(pins), .pin_o(po_le), .pin_oe_o(oe_le));

  gpio_mmio_port #(.WIDTH(W), .BIG_END(1'b1)) dut_be_i (
    .clk(clk), .rst(rst), .sel_i(sel), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd_be), .pin_i(pins), .pin_o(po_be), .pin_oe_o(oe_be));

  function automatic logic [W-1:0] rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  function automatic logic [W-1:0] nxt_out(input logic [W-1:0] o, input logic [2:0] a,
                                           input logic [W-1:0] d);
    case (a)
      3'd0: return d;
      3'd1: return o | d;
      3'd2: return o & ~d;
      default: return o;
    endcase
  endfunction

  function automatic logic [W-1:0] nxt_dir(input logic [W-1:0] dr, input logic [2:0] a,
                                           input logic [W-1:0] d);
    case (a)
      3'd3: return d;
      3'd4: return ~d;
      default: return dr;
    endcase
  endfunction

  function automatic logic [W-1:0] rd_line(input logic [2:0] a, input logic [W-1:0] o,
                                           input logic [W-1:0] dr, input logic [W-1:0] p);
    case (a)
      3'd0: return (dr & o) | (~dr & p);
      3'd1, 3'd2: return o;
      3'd3: return dr;
      3'd4: return ~dr;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_pins(input string tag);
    check({tag, " pin_o"}, po_le, m_out_le);
    check({tag, " pin_oe_o"}, oe_le, m_dir_le);
    check("R9 pin_o big-endian", po_be, m_out_be);
    check("R9 pin_oe_o big-endian", oe_be, m_dir_be);
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [W-1:0] d, input string tag);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
    m_out_le = nxt_out(m_out_le, a, d);
    m_dir_le = nxt_dir(m_dir_le, a, d);
    m_out_be = nxt_out(m_out_be, a, rev(d));
    m_dir_be = nxt_dir(m_dir_be, a, rev(d));
    check_pins(tag);
  endtask

  task automatic bus_rd(input logic [2:0] a, input string tag);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
    check({tag, " rdata"}, rd_le, rd_line(a, m_out_le, m_dir_le, pins));
    check("R9 rdata big-endian", rd_be, rev(rd_line(a, m_out_be, m_dir_be, pins)));
  endtask

  task automatic set_pins(input logic [W-1:0] v);
    @(negedge clk);
    pins = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] hold_le, hold_be;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_pins("R1 reset");
    bus_rd(3'd3, "R1 dir_out after reset");
    bus_rd(3'd4, "R1 R7 dir_in after reset");

    bus_wr(3'd1, 32'h0000_00F1, "R4 set");
    bus_wr(3'd1, 32'h8000_0000, "R4 set keeps others");
    bus_wr(3'd2, 32'h0000_0011, "R5 clear");
    bus_wr(3'd2, 32'h0000_0000, "R5 clear zero");
    bus_wr(3'd0, 32'hA5A5_1234, "R3 data write");
    bus_wr(3'd3, 32'hFFFF_0000, "R6 dir_out write");
    bus_rd(3'd3, "R6 dir_out read");
    bus_rd(3'd4, "R7 dir_in complement");

    set_pins(32'h1357_9BDF);
    bus_rd(3'd0, "R2 mixed readback");
    set_pins(32'hFFFF_FFFF);
    bus_rd(3'd0, "R2 inputs high");
    bus_rd(3'd1, "R8 set readback");
    bus_rd(3'd2, "R8 clr readback");

    bus_wr(3'd4, 32'h0000_00FF, "R7 dir_in write");
    bus_rd(3'd3, "R7 dir_out view");
    bus_rd(3'd0, "R2 after dir change");

    bus_wr(3'd6, 32'hFFFF_FFFF, "R11 unmapped write");
    bus_rd(3'd5, "R11 unmapped read");
    bus_rd(3'd7, "R11 unmapped read 7");

    bus_rd(3'd1, "R10 read");
    hold_le = rd_le; hold_be = rd_be;
    bus_wr(3'd2, 32'hFFFF_FFFF, "R5 clear all");
    bus_wr(3'd3, 32'h0F0F_0F0F, "R6 dir");
    repeat (2) @(negedge clk);
    check("R10 rdata hold", rd_le, hold_le);
    check("R10 rdata hold big-endian", rd_be, hold_be);

    for (int k = 0; k < 400; k++) begin
      logic [2:0] a;
      if ($urandom % 6 == 0) set_pins($urandom);
      a = 3'($urandom % 8);
      if ($urandom % 2) bus_wr(a, $urandom, "R3 R4 R5 R6 random write");
      else              bus_rd(a, "R2 R8 random read");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule